// File: doc/BRIEF.md
# DTMF Tone Burst Generator

This block turns one keypad digit into a timed dual-tone burst for a telephone dialer. A one-cycle strobe captures a 4-bit digit code, a single-tone flag and a tone-mode enable. The block then drives a row tone bit and a column tone bit as square waves for a minimum burst time, keeps both silent for a minimum gap, and holds a busy flag across the whole sequence. Each square wave is obtained by integer division of the crystal clock with a half-period count rounded to the nearest integer, so the tones land a few hertz away from their nominal values.

Every accepted strobe also starts a short key-acknowledge beep on its own output, whether or not tone mode is enabled. When the keypad scanner sees several keys at once it raises the single-tone flag, and only the row tone is sent. In pulse dialing, tone mode is disabled, and the burst runs silently so that the digit timing is kept.

Top module: `dtmf_burst_gen`

## Requirements
- R1: While reset is asserted and while no burst is in progress, row_tone, col_tone, busy and key_tone are all low.
- R2: A strobe sampled high while busy is low is accepted. busy is high from the cycle after the accepting edge for exactly TONE_MS+GAP_MS worth of clock cycles (CLK_HZ*ms/1000 each, truncated). It is low afterwards.
- R3: During the burst (the first CLK_HZ*TONE_MS/1000 cycles after acceptance), row_tone is a square wave. It starts low and toggles every H cycles, where H = round(CLK_HZ/(2f)). The frequency f is chosen by code bits [3:2]: 0 gives 697 Hz, 1 gives 770 Hz, 2 gives 852 Hz and 3 gives 941 Hz.
- R4: During the burst, col_tone is a square wave built the same way. Code bits [1:0] choose its frequency: 0 gives 1209 Hz, 1 gives 1336 Hz and 2 gives 1477 Hz.
- R5: A column code of 3 (bits [1:0] = 3) keeps col_tone low for the whole burst, and the row tone is sent alone.
- R6: If the single-tone flag is high at acceptance, col_tone stays low for the whole burst and only the row tone is sent.
- R7: If the tone-mode enable is low at acceptance, both tone outputs stay low for the whole burst. busy and key_tone still follow R2 and R8.
- R8: After each acceptance, key_tone is a square wave for CLK_HZ*BEEP_MS/1000 cycles. It starts low and toggles every round(CLK_HZ/(2*BEEP_HZ)) cycles, and it is low at all other times.
- R9: In the gap after the burst, both tone outputs are low while busy stays high.
- R10: A strobe that arrives while busy is high is ignored. Neither the timing nor the tones of the running burst change.
- R11: The code, single-tone flag and tone-mode enable are sampled only at acceptance. Changing them during a burst has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock (CLK_HZ) |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_stb | input | 1 | Digit strobe |
| key_code | input | 4 | Row index in [3:2], column index in [1:0] |
| single_tone | input | 1 | Send only the row tone (several keys pressed) |
| tone_en | input | 1 | Tone mode enable; low in pulse dialing |
| row_tone | output | 1 | Low-group tone square wave |
| col_tone | output | 1 | High-group tone square wave |
| busy | output | 1 | High from acceptance until the gap ends |
| key_tone | output | 1 | Key-acknowledge beep square wave |

## Verification
The bench sends one digit from each row and each column so that every divider half-period is exercised. A wrong table entry or rounding error shows up as a phase slip against the model within the first few periods. Digits with column code 3, with the single-tone flag and with tone mode disabled separate the three ways of silencing tones from each other and from the beep, which must keep running. A strobe during busy with a different code, input changes in mid-burst, and a strobe held high across two bursts together test acceptance timing, input capture and the exact burst and gap lengths.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BURST = 2'd1,
    PH_GAP   = 2'd2
  } phase_t;

  // Half-period count rounded to nearest: round(clk_hz / (2*f))
  function automatic int half_count(input int clk_hz, input int f_hz);
    int tenths;
    tenths = (clk_hz * 10) / (2 * f_hz);
    return (tenths + 5) / 10;
  endfunction

  function automatic int ms_to_cycles(input int clk_hz, input int ms);
    longint prod;
    prod = longint'(clk_hz) * longint'(ms);
    return int'(prod / 1000);
  endfunction

  function automatic int row_hz(input int idx);
    case (idx)
      0:       return 697;
      1:       return 770;
      2:       return 852;
      default: return 941;
    endcase
  endfunction

  function automatic int col_hz(input int idx);
    case (idx)
      0:       return 1209;
      1:       return 1336;
      default: return 1477;
    endcase
  endfunction

  function automatic int bits_for(input int value);
    return (value < 2) ? 1 : $clog2(value + 1);
  endfunction

endpackage

// File: rtl/dtmf_divider.sv
module dtmf_divider #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          wave
);

  logic [HW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == half - HW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      wave <= ~wave;
    end else begin
      cnt <= cnt + HW'(1);
    end
  end

  // R3
  idle_wave_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !wave);

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && half != '0) |-> (cnt < half));

endmodule

// File: rtl/dtmf_seq.sv
module dtmf_seq
  import dtmf_pkg::*;
#(
  parameter int TW    = 19,
  parameter int T_CYC = 100,
  parameter int G_CYC = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_stb,
  input  logic [3:0] key_code,
  input  logic       single_in,
  input  logic       ten_in,
  output logic       busy,
  output logic       burst_on,
  output logic       in_gap,
  output logic       accept,
  output logic [3:0] code_q,
  output logic       single_q,
  output logic       ten_q
);

  phase_t        phase;
  logic [TW-1:0] tmr;
  logic          burst_end;
  logic          gap_end;

  assign busy      = (phase != PH_IDLE);
  assign burst_on  = (phase == PH_BURST);
  assign in_gap    = (phase == PH_GAP);
  assign accept    = key_stb && !busy;
  assign burst_end = burst_on && (tmr == TW'(T_CYC - 1));
  assign gap_end   = in_gap && (tmr == TW'(G_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      tmr      <= '0;
      code_q   <= '0;
      single_q <= 1'b0;
      ten_q    <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase    <= PH_BURST;
            tmr      <= '0;
            code_q   <= key_code;
            single_q <= single_in;
            ten_q    <= ten_in;
          end
        end
        PH_BURST: begin
          if (burst_end) begin
            phase <= PH_GAP;
            tmr   <= '0;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        PH_GAP: begin
          if (gap_end) begin
            phase <= PH_IDLE;
            tmr   <= '0;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        default: begin
          phase <= PH_IDLE;
          tmr   <= '0;
        end
      endcase
    end
  end

  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> burst_on);

  // R2
  busy_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(key_stb));

  // R9
  burst_into_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_on) |-> in_gap);

  // R10
  busy_holds_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && key_stb) |=> $stable(code_q) && $stable(ten_q) && $stable(single_q));

  // R2
  no_idle_to_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !in_gap);

endmodule

// File: rtl/dtmf_beep.sv
module dtmf_beep
  import dtmf_pkg::*;
#(
  parameter int K_CYC  = 100,
  parameter int K_HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic tone,
  output logic active
);

  localparam int KW = bits_for(K_CYC);
  localparam int BW = bits_for(K_HALF);

  logic [KW-1:0] tcnt;
  logic          wave;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tcnt   <= '0;
    end else if (start) begin
      active <= 1'b1;
      tcnt   <= '0;
    end else if (active) begin
      if (tcnt == KW'(K_CYC - 1)) begin
        active <= 1'b0;
        tcnt   <= '0;
      end else begin
        tcnt <= tcnt + KW'(1);
      end
    end
  end

  dtmf_divider #(.HW(BW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (active),
    .half  (BW'(K_HALF)),
    .wave  (wave)
  );

  assign tone = wave & active;

  // R8
  beep_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !tone);

  // R8
  beep_silent_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !tone);

endmodule

// File: rtl/dtmf_burst_gen.sv
module dtmf_burst_gen
  import dtmf_pkg::*;
#(
  parameter int CLK_HZ  = 3579545,
  parameter int TONE_MS = 93,
  parameter int GAP_MS  = 93,
  parameter int BEEP_MS = 35,
  parameter int BEEP_HZ = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_stb,
  input  logic [3:0] key_code,
  input  logic       single_tone,
  input  logic       tone_en,
  output logic       row_tone,
  output logic       col_tone,
  output logic       busy,
  output logic       key_tone
);

  localparam int T_CYC  = ms_to_cycles(CLK_HZ, TONE_MS);
  localparam int G_CYC  = ms_to_cycles(CLK_HZ, GAP_MS);
  localparam int K_CYC  = ms_to_cycles(CLK_HZ, BEEP_MS);
  localparam int K_HALF = half_count(CLK_HZ, BEEP_HZ);
  localparam int MAXH   = half_count(CLK_HZ, row_hz(0));
  localparam int HW     = bits_for(MAXH);
  localparam int TW     = bits_for((T_CYC > G_CYC) ? T_CYC : G_CYC);

  logic          burst_on;
  logic          in_gap;
  logic          accept;
  logic [3:0]    code_q;
  logic          single_q;
  logic          ten_q;
  logic          row_wave;
  logic          col_wave;
  logic          beep_active;
  logic          col_allowed;
  logic [HW-1:0] row_tab [4];
  logic [HW-1:0] col_tab [4];

  genvar gi;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_tab
      assign row_tab[gi] = HW'(half_count(CLK_HZ, row_hz(gi)));
      if (gi < 3) begin : g_col
        assign col_tab[gi] = HW'(half_count(CLK_HZ, col_hz(gi)));
      end else begin : g_nocol
        assign col_tab[gi] = HW'(MAXH);
      end
    end
  endgenerate

  dtmf_seq #(.TW(TW), .T_CYC(T_CYC), .G_CYC(G_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_stb   (key_stb),
    .key_code  (key_code),
    .single_in (single_tone),
    .ten_in    (tone_en),
    .busy      (busy),
    .burst_on  (burst_on),
    .in_gap    (in_gap),
    .accept    (accept),
    .code_q    (code_q),
    .single_q  (single_q),
    .ten_q     (ten_q)
  );

  dtmf_divider #(.HW(HW)) u_row (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (burst_on),
    .half  (row_tab[code_q[3:2]]),
    .wave  (row_wave)
  );

  dtmf_divider #(.HW(HW)) u_col (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (burst_on),
    .half  (col_tab[code_q[1:0]]),
    .wave  (col_wave)
  );

  dtmf_beep #(.K_CYC(K_CYC), .K_HALF(K_HALF)) u_beep (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .tone   (key_tone),
    .active (beep_active)
  );

  assign col_allowed = ten_q && !single_q && (code_q[1:0] != 2'd3);
  assign row_tone    = burst_on && ten_q && row_wave;
  assign col_tone    = burst_on && col_allowed && col_wave;

  // R9
  gap_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> (!row_tone && !col_tone && busy));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!row_tone && !col_tone && !key_tone));

  // R7
  pulse_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ten_q) |-> (!row_tone && !col_tone));

  // R8
  beep_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beep_active |-> busy);

endmodule

// File: tb/sim_dtmf_burst_gen.sv
module sim_dtmf_burst_gen;

  localparam int CLK_PERIOD = 10;
  localparam int SIM_HZ     = 40000;
  localparam int T_LEN      = SIM_HZ * 93 / 1000;
  localparam int G_LEN      = SIM_HZ * 93 / 1000;
  localparam int K_LEN      = SIM_HZ * 35 / 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_stb = 1'b0;
  logic [3:0] key_code = 4'd0;
  logic       single_tone = 1'b0;
  logic       tone_en = 1'b1;
  logic       row_tone, col_tone, busy, key_tone;

  int vectors = 0;
  int fails = 0;
  int k = -1;
  int m_code = 0;
  bit m_single = 1'b0;
  bit m_ten = 1'b0;
  bit chk_on = 1'b0;
  string ctx = "R1 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  dtmf_burst_gen #(.CLK_HZ(SIM_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .key_stb(key_stb), .key_code(key_code),
    .single_tone(single_tone), .tone_en(tone_en),
    .row_tone(row_tone), .col_tone(col_tone), .busy(busy), .key_tone(key_tone)
  );

  function automatic int hp(input int f);
    return (SIM_HZ + f) / (2 * f);
  endfunction

  function automatic int row_f(input int r);
    int tab[4] = '{697, 770, 852, 941};
    return tab[r];
  endfunction

  function automatic int col_f(input int c);
    int tab[3] = '{1209, 1336, 1477};
    return tab[c];
  endfunction

  function automatic bit sq(input int t, input int h);
    return ((t / h) % 2) == 1;
  endfunction

  // reference model: time since acceptance
  always @(posedge clk) begin
    if (!rst_n) k = -1;
    else if (k >= 0) begin
      k = k + 1;
      if (k >= T_LEN + G_LEN) k = -1;
    end else if (key_stb) begin
      k = 0;
      m_code = int'(key_code);
      m_single = single_tone;
      m_ten = tone_en;
    end
  end

  task automatic cmp(input string tag, input bit act, input bit exp, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) %s at k=%0d: actual %0b expected %0b", tag, ctx, what, k, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      bit e_row, e_col, e_busy, e_key;
      int r, c;
      string trow, tcol;
      r = m_code / 4;
      c = m_code % 4;
      e_busy = (k >= 0);
      e_key  = (k >= 0) && (k < K_LEN) && sq(k, hp(1200));
      e_row  = (k >= 0) && (k < T_LEN) && m_ten && sq(k, hp(row_f(r)));
      e_col  = (k >= 0) && (k < T_LEN) && m_ten && !m_single && (c != 3) && sq(k, hp(col_f(c)));
      if (!rst_n || k < 0) begin
        trow = "R1"; tcol = "R1";
      end else if (k >= T_LEN) begin
        trow = "R9"; tcol = "R9";
      end else if (!m_ten) begin
        trow = "R7"; tcol = "R7";
      end else begin
        trow = "R3";
        tcol = m_single ? "R6" : (c == 3) ? "R5" : "R4";
      end
      cmp(trow, row_tone, e_row, "row_tone");
      cmp(tcol, col_tone, e_col, "col_tone");
      cmp((k < 0) ? "R1" : "R2", busy, e_busy, "busy");
      cmp("R8", key_tone, e_key, "key_tone");
    end
  end

  task automatic press(input int code, input bit single, input bit ten);
    @(negedge clk);
    key_code = 4'(code);
    single_tone = single;
    tone_en = ten;
    key_stb = 1'b1;
    @(negedge clk);
    key_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_on = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    ctx = "R3 R4 row0 col0";       press(0, 0, 1);  idle(T_LEN + G_LEN + 2);
    ctx = "R3 R4 row1 col1";       press(5, 0, 1);  idle(T_LEN + G_LEN + 2);
    ctx = "R3 R4 row2 col2";       press(10, 0, 1); idle(T_LEN + G_LEN + 2);
    ctx = "R3 R5 row3 col3";       press(15, 0, 1); idle(T_LEN + G_LEN + 2);
    ctx = "R3 R4 row3 col0";       press(12, 0, 1); idle(T_LEN + G_LEN + 2);
    ctx = "R6 single tone";        press(2, 1, 1);  idle(T_LEN + G_LEN + 2);
    ctx = "R7 pulse mode";         press(9, 0, 0);  idle(T_LEN + G_LEN + 2);

    ctx = "R10 strobe while busy";
    press(1, 0, 1);
    idle(100);
    press(14, 1, 0);
    idle(T_LEN - 50);
    press(6, 0, 1);
    idle(T_LEN + G_LEN);

    ctx = "R11 inputs change mid-burst";
    press(4, 0, 1);
    idle(60);
    key_code = 4'd11; single_tone = 1'b1; tone_en = 1'b0;
    idle(T_LEN + G_LEN);
    tone_en = 1'b1; single_tone = 1'b0;

    ctx = "R2 strobe held across two bursts";
    @(negedge clk);
    key_code = 4'd9; key_stb = 1'b1;
    idle(T_LEN + G_LEN + 3);
    key_stb = 1'b0;
    idle(T_LEN + G_LEN + 3);

    ctx = "R1 reset mid-burst";
    press(6, 0, 1);
    idle(40);
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule